// File: doc/BRIEF.md
# Fractional Clock Prescaler

This block turns a fast reference clock into a train of single-cycle enable pulses whose average spacing is a programmable ratio made of a whole part and eighths. A baud-rate divisor placed after it counts these pulses, so one reference crystal can serve many standard and high serial rates. The ratio runs from 1 up to 31 and 7/8 in steps of 1/8, which gives 248 usable settings.

Each output period lasts either the whole part or the whole part plus one reference cycle. A three-bit accumulator adds the eighths once per period, and each carry out of it adds one cycle to the period that follows. Ratio writes take effect only at a period boundary, so no period is ever cut short. A bypass input, or a whole part of zero, makes every reference cycle an enable. The reset input is asynchronous and active low; the block synchronises its release internally.

Top module: `frac_prescaler`

## Requirements
- R1: `tick_out` stays low while `rst_n` is low and for the first clock edge after `rst_n` rises; from the second edge onward the block runs.
- R2: With whole part M (1 to 31) and eighths N (0 to 7), every gap between consecutive `tick_out` pulses is exactly M or M+1 clock cycles.
- R3: Any 8 consecutive gaps under one setting add up to exactly 8*M+N clock cycles.
- R4: After a new ratio is taken, gap number j (counting from 1) is M + floor(j*N/8) - floor((j-1)*N/8) cycles. The accumulator starts again from zero.
- R5: Whole part 1 with eighths 0 gives a pulse on every clock cycle.
- R6: While `bypass_en` is high, `tick_out` is high on every cycle. After `bypass_en` falls, periods follow the programmed ratio again.
- R7: A whole part of 0 is illegal. Once it is taken at a period boundary, `tick_out` is high on every cycle, as in bypass.
- R8: A change to `ratio_int` or `ratio_frac` in the middle of a period does not shorten or lengthen that period. It is taken on the clock edge that ends the period (when `tick_out` is high), and the accumulator restarts from zero.
- R9: All 248 settings (M from 1 to 31, N from 0 to 7) give the gap pattern of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| bypass_en | input | 1 | Forces an enable on every cycle |
| ratio_int | input | INT_W (5) | Whole part M of the ratio |
| ratio_frac | input | FRAC_W (3) | Eighths N of the ratio |
| tick_out | output | 1 | Single-cycle clock-enable pulse train |

## Verification
The bench sweeps every one of the 248 legal ratios in turn. For each one it measures eight gaps, checks each gap against the floor formula, and checks their sum against 8*M+N. The per-gap checks catch stretches placed on the wrong periods or an accumulator that was not cleared after a change. The sum checks catch a wrong count of stretched periods. Separate patterns change the ratio mid-period, which tells a period that finishes correctly from a runt, and switch from one fraction to another so that accumulator state left over from the old setting shows up. Further patterns drive bypass and a zero whole part, which must both give a pulse every cycle, then return to normal periods.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int FP_INT_W_DEF  = 5;
  localparam int FP_FRAC_W_DEF = 3;
endpackage

// File: rtl/fp_rst_sync.sv
module fp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/fp_ratio_hold.sv
module fp_ratio_hold #(
  parameter int INT_W  = 5,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bypass,
  input  logic [INT_W-1:0]  in_m,
  input  logic [FRAC_W-1:0] in_n,
  output logic [INT_W-1:0]  act_m,
  output logic              stretch
);
  logic [INT_W-1:0]  act_m_q, act_m_d;
  logic [FRAC_W-1:0] act_n_q, act_n_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic              str_q, str_d;
  logic              changed, idle;
  logic [FRAC_W-1:0] base, nuse;
  logic [FRAC_W:0]   sum;

  always_comb begin
    changed = (in_m != act_m_q) || (in_n != act_n_q);
    idle    = bypass || (in_m == '0);
    base    = (changed || idle) ? '0 : acc_q;
    nuse    = changed ? in_n : act_n_q;
    sum     = {1'b0, base} + {1'b0, nuse};
    act_m_d = act_m_q;
    act_n_d = act_n_q;
    acc_d   = acc_q;
    str_d   = str_q;
    if (tick) begin
      act_m_d = in_m;
      act_n_d = in_n;
      acc_d   = sum[FRAC_W-1:0];
      str_d   = sum[FRAC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_m_q <= {{(INT_W-1){1'b0}}, 1'b1};
      act_n_q <= '0;
      acc_q   <= '0;
      str_q   <= 1'b0;
    end else begin
      act_m_q <= act_m_d;
      act_n_q <= act_n_d;
      acc_q   <= acc_d;
      str_q   <= str_d;
    end
  end

  assign act_m   = act_m_q;
  assign stretch = str_q;

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(act_m_q) && $stable(act_n_q))); // R8

  AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && changed) |=> !str_q); // R4
endmodule

// File: rtl/fp_period_cnt.sv
module fp_period_cnt #(
  parameter int INT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             force_every,
  input  logic [INT_W-1:0] act_m,
  input  logic             stretch,
  output logic             tick
);
  localparam int LEN_W = INT_W + 1;

  logic [INT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] plen;
  logic             at_end;

  always_comb begin
    plen   = {1'b0, act_m} + {{(LEN_W-1){1'b0}}, stretch};
    at_end = (({1'b0, cnt_q} + {{(LEN_W-1){1'b0}}, 1'b1}) == plen);
    tick   = run && (force_every || at_end);
    cnt_d  = cnt_q;
    if (tick)     cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_m); // R2

  AST_ZERO_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_m == '0) |-> tick); // R7
endmodule

// File: rtl/frac_prescaler.sv
module frac_prescaler
  import fp_pkg::*;
#(
  parameter int INT_W  = FP_INT_W_DEF,
  parameter int FRAC_W = FP_FRAC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass_en,
  input  logic [INT_W-1:0]  ratio_int,
  input  logic [FRAC_W-1:0] ratio_frac,
  output logic              tick_out
);
  logic             sync_n;
  logic [INT_W-1:0] act_m;
  logic             stretch;
  logic             tick;
  logic             force_every;

  fp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n)
  );

  assign force_every = bypass_en || (act_m == '0);

  fp_ratio_hold #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_hold (
    .clk(clk), .rst_n(sync_n), .tick(tick), .bypass(bypass_en),
    .in_m(ratio_int), .in_n(ratio_frac), .act_m(act_m), .stretch(stretch)
  );

  fp_period_cnt #(.INT_W(INT_W)) u_cnt (
    .clk(clk), .rst_n(sync_n), .run(sync_n), .force_every(force_every),
    .act_m(act_m), .stretch(stretch), .tick(tick)
  );

  assign tick_out = tick;

  AST_QUIET_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> !tick_out); // R1

  AST_BYPASS_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n && bypass_en) |-> tick_out); // R6
endmodule

// File: tb/frac_prescaler_test.sv
module frac_prescaler_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bypass_en;
  logic [4:0] ratio_int;
  logic [2:0] ratio_frac;
  logic       tick_out;
  int checks = 0;
  int errors = 0;
  int settings = 0;

  always #5 clk = ~clk;

  frac_prescaler uut (
    .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en),
    .ratio_int(ratio_int), .ratio_frac(ratio_frac), .tick_out(tick_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick(output int gap);
    gap = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      gap++;
      if (tick_out) break;
    end
  endtask

  function automatic int exp_gap(input int m, input int n, input int j);
    return m + (j * n) / 8 - ((j - 1) * n) / 8;
  endfunction

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int g;
    int tot;
    rst_n = 1'b0; bypass_en = 1'b0; ratio_int = 5'd1; ratio_frac = 3'd0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R1 tick during reset", int'(tick_out), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tick during sync", int'(tick_out), 0);
    wait_tick(g);

    // Sweep of every legal ratio
    for (int m = 1; m < 32; m++) begin
      for (int n = 0; n < 8; n++) begin
        ratio_int = 5'(m); ratio_frac = 3'(n);
        settings++;
        tot = 0;
        for (int j = 1; j <= 8; j++) begin
          wait_tick(g);
          tot += g;
          if (m == 1 && n == 0) check("R5 unit ratio gap", g, 1);
          else if (g != m && g != m + 1) check("R2 gap bound", g, m);
          else check("R4 R9 gap pattern", g, exp_gap(m, n, j));
        end
        check("R3 eight-gap sum", tot, 8 * m + n);
      end
    end
    check("R9 settings swept", settings, 248);

    // Bypass
    bypass_en = 1'b1; ratio_int = 5'd3; ratio_frac = 3'd0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check("R6 bypass every cycle", int'(tick_out), 1);
    end
    bypass_en = 1'b0;
    wait_tick(g);
    for (int j = 0; j < 2; j++) begin
      wait_tick(g);
      check("R6 after bypass", g, 3);
    end

    // Illegal whole part
    ratio_int = 5'd0;
    wait_tick(g);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check("R7 zero whole part", int'(tick_out), 1);
    end

    // Mid-period change
    ratio_int = 5'd10; ratio_frac = 3'd0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 no early tick", int'(tick_out), 0);
    end
    ratio_int = 5'd2;
    wait_tick(g);
    check("R8 period completes", g, 6);
    for (int j = 0; j < 2; j++) begin
      wait_tick(g);
      check("R8 new ratio", g, 2);
    end

    // Accumulator restart on fraction change
    ratio_frac = 3'd5;
    for (int j = 1; j <= 3; j++) begin
      wait_tick(g);
      check("R4 fraction five", g, exp_gap(2, 5, j));
    end
    ratio_frac = 3'd4;
    for (int j = 1; j <= 4; j++) begin
      wait_tick(g);
      check("R8 accumulator restart", g, exp_gap(2, 4, j));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule